// File: doc/BRIEF.md
# Hold and Breakpoint Controller

This block parks the processor at an instruction boundary and hands the system buses to another master. A hold can start in two ways. An external device can pull the active-low hold request low. The hold then begins when the instruction in flight reports completion. A decoded breakpoint instruction also starts a hold, but only when the configuration input shows that a console is attached. With no console the breakpoint is a no-operation.

While held, the block drives the active-low acknowledge low and raises the processor-suspend output. It also raises one tri-state enable for each bus driver group: address/data, strobe, mode and direction. The two causes end in different ways. An external hold ends as soon as the request line reads high. A breakpoint hold needs a complete pulse on the request line, first low and then high again. The request input is expected to arrive already synchronized to the bus address strobe. All pins are plain control levels or pulses, with no handshake.

Top module: `hold_bpt_ctrl`

## Requirements
- R1: While reset is low, and after it is released with no other stimulus, `hold_ack_n` is 1, `cpu_suspend` is 0 and every `bus_hiz` bit is 0.
- R2: A low `hold_req_n` without `instr_done` leaves the block running. An `instr_done` pulse while `hold_req_n` is high also leaves it running.
- R3: When `hold_req_n` is 0 at a clock edge where `instr_done` is 1, the outputs after that edge show the hold: `hold_ack_n`=0, `cpu_suspend`=1, all `bus_hiz` bits 1.
- R4: An external hold ends at the first clock edge where `hold_req_n` is sampled 1. The outputs return to the running values after that edge.
- R5: A `bpt_hit` pulse with `console_n`=0 (console present) enters the hold at that edge, whatever the levels of `instr_done` and `hold_req_n`.
- R6: A `bpt_hit` pulse with `console_n`=1 is ignored. The outputs stay at the running values.
- R7: A breakpoint hold survives while `hold_req_n` stays high. It ends only at the edge where a rise of `hold_req_n` (0 now, 1 at the previous edge reversed: 1 now, 0 at the previous edge) follows a fall (1 at the previous edge, 0 now) seen during the hold. `instr_done` has no effect during the hold.
- R8: If `hold_req_n` is already low when a breakpoint hold begins, its later rise does not end the hold. A fresh fall and rise are needed.
- R9: When `bpt_hit` (with console) and an external entry (`hold_req_n`=0 with `instr_done`) occur at the same edge, the breakpoint hold is taken. Releasing the request then does not end it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_req_n | input | 1 | Active-low hold request, synchronized to the address strobe |
| instr_done | input | 1 | One-cycle pulse at the end of each instruction |
| bpt_hit | input | 1 | One-cycle pulse when a breakpoint instruction is decoded |
| console_n | input | 1 | Configuration bit, 0 when a console is present |
| hold_ack_n | output | 1 | Active-low hold acknowledge |
| cpu_suspend | output | 1 | High while the processor must stay suspended |
| bus_hiz | output | BUS_GROUPS | Tri-state enables for the bus driver groups, all high while held |

## Verification
The assertions assume `hold_req_n` changes only between clock edges and is already synchronous. They also assume `instr_done` and `bpt_hit` are single-cycle pulses that are never raised during a hold, since the processor is suspended. The stimulus changes every input shortly after a rising edge and keeps it steady through the next edge. Pulses are issued only while the block is running, except for one deliberate `instr_done` inside a breakpoint hold. That pulse checks that it has no effect.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
  typedef enum logic [1:0] {
    HS_RUN     = 2'd0,
    HS_EXT     = 2'd1,
    HS_BPT_ARM = 2'd2,
    HS_BPT_LOW = 2'd3
  } hold_state_t;
endpackage

// File: rtl/hbc_edge.sv
module hbc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  output logic fall,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= req_n;
  end

  assign fall = prev_q & ~req_n;
  assign rise = ~prev_q & req_n;
endmodule

// File: rtl/hbc_fsm.sv
module hbc_fsm
  import hbc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_n,
  input  logic        fall,
  input  logic        rise,
  input  logic        instr_done,
  input  logic        bpt_hit,
  input  logic        console_ok,
  output hold_state_t state_q
);
  hold_state_t state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      HS_RUN: begin
        if (bpt_hit && console_ok)       state_d = HS_BPT_ARM;
        else if (!req_n && instr_done)   state_d = HS_EXT;
      end
      HS_EXT:     if (req_n) state_d = HS_RUN;
      HS_BPT_ARM: if (fall)  state_d = HS_BPT_LOW;
      HS_BPT_LOW: if (rise)  state_d = HS_RUN;
      default:               state_d = HS_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= HS_RUN;
    else        state_q <= state_d;
  end

  AST_RUN_WAITS_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_RUN && !instr_done && !bpt_hit) |=> state_q == HS_RUN); // R2
  AST_EXT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_RUN && !req_n && instr_done && !(bpt_hit && console_ok)) |=> state_q == HS_EXT); // R3
  AST_EXT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_EXT && req_n) |=> state_q == HS_RUN); // R4
  AST_BPT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_RUN && bpt_hit && console_ok) |=> state_q == HS_BPT_ARM); // R5
  AST_NOCONSOLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_RUN && bpt_hit && !console_ok && !(instr_done && !req_n)) |=> state_q == HS_RUN); // R6
  AST_BPT_NEEDS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_BPT_ARM) |=> state_q != HS_RUN); // R7
endmodule

// File: rtl/hbc_drive.sv
module hbc_drive
  import hbc_pkg::*;
#(
  parameter int BUS_GROUPS = 4
) (
  input  hold_state_t           state_q,
  output logic                  hold_ack_n,
  output logic                  cpu_suspend,
  output logic [BUS_GROUPS-1:0] bus_hiz
);
  logic held;
  assign held        = (state_q != HS_RUN);
  assign hold_ack_n  = ~held;
  assign cpu_suspend = held;

  for (genvar g = 0; g < BUS_GROUPS; g++) begin : g_grp
    assign bus_hiz[g] = held;
  end
endmodule

// File: rtl/hold_bpt_ctrl.sv
module hold_bpt_ctrl
  import hbc_pkg::*;
#(
  parameter int BUS_GROUPS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hold_req_n,
  input  logic                  instr_done,
  input  logic                  bpt_hit,
  input  logic                  console_n,
  output logic                  hold_ack_n,
  output logic                  cpu_suspend,
  output logic [BUS_GROUPS-1:0] bus_hiz
);
  localparam logic [BUS_GROUPS-1:0] ALL_HIZ = {BUS_GROUPS{1'b1}};

  logic        fall, rise;
  hold_state_t state_q;

  hbc_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .req_n (hold_req_n),
    .fall  (fall),
    .rise  (rise)
  );

  hbc_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_n      (hold_req_n),
    .fall       (fall),
    .rise       (rise),
    .instr_done (instr_done),
    .bpt_hit    (bpt_hit),
    .console_ok (~console_n),
    .state_q    (state_q)
  );

  hbc_drive #(.BUS_GROUPS(BUS_GROUPS)) u_drive (
    .state_q     (state_q),
    .hold_ack_n  (hold_ack_n),
    .cpu_suspend (cpu_suspend),
    .bus_hiz     (bus_hiz)
  );

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    !rst_n |=> (hold_ack_n && !cpu_suspend)); // R1
  AST_ACK_FLOATS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_ack_n |-> (bus_hiz == ALL_HIZ && cpu_suspend)); // R3
  AST_BPT_REQ_HIGH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_BPT_ARM && hold_req_n) |=> !hold_ack_n); // R7
endmodule

// File: tb/hold_bpt_ctrl_bench.sv
module hold_bpt_ctrl_bench;
  localparam int G = 4;

  logic clk = 1'b0;
  logic rst_n, hold_req_n, instr_done, bpt_hit, console_n;
  logic hold_ack_n, cpu_suspend;
  logic [G-1:0] bus_hiz;

  int checks = 0;
  int fails  = 0;
  string phase = "R1";

  int mstate = 0;
  bit mprev  = 1'b1;

  always #4 clk = ~clk;

  hold_bpt_ctrl #(.BUS_GROUPS(G)) u_hold_bpt_ctrl (
    .clk(clk), .rst_n(rst_n), .hold_req_n(hold_req_n), .instr_done(instr_done),
    .bpt_hit(bpt_hit), .console_n(console_n), .hold_ack_n(hold_ack_n),
    .cpu_suspend(cpu_suspend), .bus_hiz(bus_hiz)
  );

  task automatic model_edge();
    bit fall_e, rise_e;
    if (!rst_n) begin
      mstate = 0; mprev = 1'b1;
    end else begin
      fall_e = mprev && !hold_req_n;
      rise_e = !mprev && hold_req_n;
      if (mstate == 0) begin
        if (bpt_hit && !console_n) mstate = 2;
        else if (!hold_req_n && instr_done) mstate = 1;
      end else if (mstate == 1) begin
        if (hold_req_n) mstate = 0;
      end else if (mstate == 2) begin
        if (fall_e) mstate = 3;
      end else begin
        if (rise_e) mstate = 0;
      end
      mprev = hold_req_n;
    end
  endtask

  task automatic compare();
    bit held = (mstate != 0);
    logic [G-1:0] ehiz = held ? {G{1'b1}} : {G{1'b0}};
    checks++;
    if (hold_ack_n !== !held || cpu_suspend !== held || bus_hiz !== ehiz) begin
      fails++;
      $display("FAIL %s: ack_n=%b suspend=%b hiz=%b expected ack_n=%b suspend=%b hiz=%b",
               phase, hold_ack_n, cpu_suspend, bus_hiz, !held, held, ehiz);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      #2;
      compare();
      instr_done = 1'b0;
      bpt_hit    = 1'b0;
    end
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hold_req_n = 1'b1; instr_done = 1'b0; bpt_hit = 1'b0; console_n = 1'b1;
    phase = "R1"; tick(3);
    rst_n = 1'b1; tick(2);

    phase = "R2"; hold_req_n = 1'b0; tick(3);
    hold_req_n = 1'b1; instr_done = 1'b1; tick(2);
    phase = "R3"; hold_req_n = 1'b0; tick(2);
    instr_done = 1'b1; tick(4);
    phase = "R4"; hold_req_n = 1'b1; tick(3);

    phase = "R6"; console_n = 1'b1; bpt_hit = 1'b1; tick(3);
    hold_req_n = 1'b0; bpt_hit = 1'b1; tick(1);
    hold_req_n = 1'b1; tick(2);

    phase = "R5"; console_n = 1'b0; bpt_hit = 1'b1; tick(2);
    phase = "R7"; tick(3);
    instr_done = 1'b1; tick(2);
    hold_req_n = 1'b0; tick(2);
    hold_req_n = 1'b1; tick(3);

    phase = "R8"; hold_req_n = 1'b0; tick(2);
    bpt_hit = 1'b1; tick(2);
    hold_req_n = 1'b1; tick(3);
    hold_req_n = 1'b0; tick(1);
    hold_req_n = 1'b1; tick(3);

    phase = "R9"; hold_req_n = 1'b0; tick(1);
    instr_done = 1'b1; bpt_hit = 1'b1; tick(2);
    hold_req_n = 1'b1; tick(3);
    hold_req_n = 1'b0; tick(1);
    hold_req_n = 1'b1; tick(3);

    phase = "R5"; hold_req_n = 1'b1; bpt_hit = 1'b1; instr_done = 1'b1; tick(2);
    hold_req_n = 1'b0; tick(1);
    hold_req_n = 1'b1; tick(2);

    phase = "R1"; rst_n = 1'b0; hold_req_n = 1'b0; tick(2);
    rst_n = 1'b1; hold_req_n = 1'b1; tick(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule